// File: doc/BRIEF.md
# CPU Interrupt and Reset Entry Sequencer

This block sits beside an 8-bit CPU core whose stack lives in page one of memory. The core keeps the program counter, stack pointer and status register. At every instruction boundary it pulses `boundary_i` and presents those three values. The sequencer decides in that same cycle whether a handler must be entered. If one is entered, `busy_o` rises at once, so the core does not fetch an opcode. The block then pushes the return state through its own byte-wide memory port and fetches the handler address. One cycle after `busy_o` falls, `done_o` pulses and the new program counter, status and stack pointer are offered for the core to load.

Interrupt requests arrive from several sources and are held as a bitmask of pending bits. Bit 0 is the non-maskable request. Bit 1 is a one-shot maskable request. Every higher bit is a level-held maskable source that stays set until its owner clears it. The maskable path is gated by the interrupt-disable flag as it was captured at the previous boundary, not by the value presented now. A halted (jammed) core takes no interrupts. A reset, either the asynchronous `rst_ni` or the synchronous `reset_req_i`, runs the same sequence frame without stack writes and loads the reset handler address.

Top module: `cpu_intr_seq`

## Requirements
- R1: `pending_o` bit i is set by `req_set_i[i]` and cleared by `req_clr_i[i]`, visible on the next cycle. When both are high for the same bit in the same cycle, the clear wins. Bit 0 is the non-maskable request, bit 1 the one-shot request, and bits 2 and up are level sources.
- R2: A check happens when `boundary_i` is high and no sequence is running. If pending bit 0 is set, a non-maskable entry starts. Otherwise, if any other pending bit is set and the mask sample is 0, a maskable entry starts. Otherwise nothing starts and `busy_o` stays low.
- R3: The mask sample is bit 2 (interrupt disable) of `status_i` captured at the previous check that started nothing. After an entry or reset sequence it is bit 2 of the new `status_o`. It is 1 after `rst_ni`.
- R4: An entry keeps `busy_o` high for exactly 7 cycles, counting the boundary cycle. In cycles 3, 4 and 5 it writes, in order: PC[15:8] to 0x0100+S, PC[7:0] to 0x0100+S-1, and the status with bit 4 cleared and bit 5 set to 0x0100+S-2. The low byte of each address wraps at 8 bits. `sp_o` ends at S-3.
- R5: In cycles 6 and 7 the block reads the handler address, low byte first: from 0xFFFA/0xFFFB for a non-maskable entry, from 0xFFFE/0xFFFF for a maskable one. The bytes are loaded into `pc_o`. `done_o` pulses in the cycle after `busy_o` falls.
- R6: `status_o` after a maskable entry is the sampled status with bit 4 cleared and bit 2 set. After a non-maskable entry it is the sampled status with bit 4 cleared only.
- R7: Every check clears pending bits 0 and 1, whether or not an entry starts. Level bits keep their value. A set of bit 0 or 1 arriving in the check cycle survives the check.
- R8: `jam_set_i` sets `jammed_o`. While `jammed_o` is high, a check starts no entry but still applies the clearing of R7.
- R9: A reset clears `jammed_o` and keeps the pending bits. It performs no memory writes and reads 0xFFFC then 0xFFFD into `pc_o`. It gives `status_o` = 0x04 and leaves `sp_o` at the `sp_i` presented with `reset_req_i` (0 after `rst_ni`). Busy lasts 6 cycles after `rst_ni` rises, or 7 cycles including the `reset_req_i` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; starts a reset sequence on release |
| boundary_i | input | 1 | Core is at an instruction boundary |
| pc_i | input | 16 | Core program counter at the boundary |
| status_i | input | 8 | Core status register at the boundary |
| sp_i | input | 8 | Core stack pointer at the boundary or reset request |
| reset_req_i | input | 1 | Synchronous CPU reset request |
| jam_set_i | input | 1 | Core has halted on a jam opcode |
| req_set_i | input | NUM_SRC | Per-source request set mask |
| req_clr_i | input | NUM_SRC | Per-source request clear mask |
| mem_rdata_i | input | 8 | Read data, sampled at the edge ending a read cycle |
| mem_addr_o | output | 16 | Memory address |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |
| busy_o | output | 1 | Sequence in progress; core must not fetch |
| done_o | output | 1 | One-cycle pulse: pc_o, status_o, sp_o are ready to load |
| pc_o | output | 16 | Handler program counter |
| status_o | output | 8 | New status register |
| sp_o | output | 8 | New stack pointer |
| pending_o | output | NUM_SRC | Pending request bits |
| jammed_o | output | 1 | Core halted; interrupt entry blocked |

## Verification
In the cycle of a check, two things can meet: the self-clear of the non-maskable and one-shot bits, and a fresh set of those bits from a source. The bench raises `req_set_i[0]` in the boundary cycle of a non-maskable entry. It then expects the entry to run and bit 0 to still be pending afterwards. A set and a clear of one level bit are also driven in the same cycle, and the bench expects the bit to read back clear. Sweeping all pending masks against both mask-sample values, with the presented interrupt-disable flag inverted, shows that the previous boundary's flag decides the outcome.

// File: rtl/cis_pkg.sv
package cis_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DUM, ST_PCH, ST_PCL, ST_PST, ST_VLO, ST_VHI
  } seq_state_e;

  typedef enum logic [1:0] {K_RST, K_NMI, K_IRQ} entry_kind_e;

  localparam int unsigned NMI_BIT = 0;
  localparam int unsigned ONE_BIT = 1;
  localparam int unsigned I_POS   = 2;

  localparam logic [7:0] FLG_I      = 8'h04;
  localparam logic [7:0] FLG_B      = 8'h10;
  localparam logic [7:0] FLG_U      = 8'h20;
  localparam logic [7:0] STACK_PAGE = 8'h01;

  localparam logic [15:0] VEC_NMI = 16'hFFFA;
  localparam logic [15:0] VEC_RST = 16'hFFFC;
  localparam logic [15:0] VEC_IRQ = 16'hFFFE;

  function automatic logic [15:0] vec_base(entry_kind_e k);
    case (k)
      K_NMI:   return VEC_NMI;
      K_IRQ:   return VEC_IRQ;
      default: return VEC_RST;
    endcase
  endfunction
endpackage

// File: rtl/cis_req_reg.sv
module cis_req_reg #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               self_clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  import cis_pkg::*;

  logic [NUM_SRC-1:0] sc_mask;
  logic [NUM_SRC-1:0] pend_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sc
    if (i == NMI_BIT || i == ONE_BIT) begin : g_auto
      assign sc_mask[i] = self_clr_i;
    end else begin : g_level
      assign sc_mask[i] = 1'b0;
    end
  end

  // fresh set survives self-clear; explicit clear wins over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= ((pend_q & ~sc_mask) | set_i) & ~clr_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/cis_arbiter.sv
module cis_arbiter #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               boundary_i,
  input  logic               idle_i,
  input  logic               reset_req_i,
  input  logic               mask_i,
  input  logic               jammed_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               check_o,
  output logic               take_nmi_o,
  output logic               take_irq_o
);
  import cis_pkg::*;

  logic nmi_pend, irq_pend;

  assign nmi_pend   = pend_i[NMI_BIT];
  assign irq_pend   = |pend_i[NUM_SRC-1:1];
  assign check_o    = boundary_i & idle_i & ~reset_req_i;
  assign take_nmi_o = check_o & ~jammed_i & nmi_pend;
  assign take_irq_o = check_o & ~jammed_i & ~nmi_pend & irq_pend & ~mask_i;
endmodule

// File: rtl/cis_seq_fsm.sv
module cis_seq_fsm (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        boundary_i,
  input  logic        take_nmi_i,
  input  logic        take_irq_i,
  input  logic        reset_req_i,
  input  logic        jam_set_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  status_i,
  input  logic [7:0]  sp_i,
  input  logic [7:0]  mem_rdata_i,
  output logic        idle_o,
  output logic        mask_o,
  output logic        jammed_o,
  output logic [15:0] mem_addr_o,
  output logic        mem_wr_o,
  output logic        mem_rd_o,
  output logic [7:0]  mem_wdata_o,
  output logic        done_o,
  output logic [15:0] pc_o,
  output logic [7:0]  status_o,
  output logic [7:0]  sp_o
);
  import cis_pkg::*;

  seq_state_e  state_q;
  entry_kind_e kind_q;
  logic [15:0] pc_q;
  logic [7:0]  st_q, sp_q;
  logic        mask_q, jam_q, done_q;
  logic        push;

  assign push = (kind_q != K_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DUM;
      kind_q  <= K_RST;
      pc_q    <= '0;
      st_q    <= '0;
      sp_q    <= '0;
      mask_q  <= 1'b1;
      jam_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (jam_set_i) jam_q <= 1'b1;
      if (reset_req_i) begin
        state_q <= ST_DUM;
        kind_q  <= K_RST;
        sp_q    <= sp_i;
        jam_q   <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: if (boundary_i) begin
            if (take_nmi_i || take_irq_i) begin
              state_q <= ST_DUM;
              kind_q  <= take_nmi_i ? K_NMI : K_IRQ;
              pc_q    <= pc_i;
              st_q    <= status_i;
              sp_q    <= sp_i;
            end else begin
              mask_q  <= status_i[I_POS];
            end
          end
          ST_DUM: state_q <= ST_PCH;
          ST_PCH: begin
            state_q <= ST_PCL;
            if (push) sp_q <= sp_q - 8'd1;
          end
          ST_PCL: begin
            state_q <= ST_PST;
            if (push) sp_q <= sp_q - 8'd1;
          end
          ST_PST: begin
            state_q <= ST_VLO;
            if (push) begin
              sp_q <= sp_q - 8'd1;
              st_q <= (st_q & ~FLG_B) | ((kind_q == K_IRQ) ? FLG_I : 8'h00);
            end else begin
              st_q <= FLG_I;
            end
          end
          ST_VLO: begin
            state_q    <= ST_VHI;
            pc_q[7:0]  <= mem_rdata_i;
          end
          ST_VHI: begin
            state_q    <= ST_IDLE;
            pc_q[15:8] <= mem_rdata_i;
            done_q     <= 1'b1;
            mask_q     <= st_q[I_POS];
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    mem_wr_o    = 1'b0;
    mem_rd_o    = 1'b0;
    mem_addr_o  = {STACK_PAGE, sp_q};
    mem_wdata_o = '0;
    case (state_q)
      ST_PCH: begin mem_wr_o = push; mem_wdata_o = pc_q[15:8]; end
      ST_PCL: begin mem_wr_o = push; mem_wdata_o = pc_q[7:0]; end
      ST_PST: begin mem_wr_o = push; mem_wdata_o = (st_q & ~FLG_B) | FLG_U; end
      ST_VLO: begin mem_rd_o = 1'b1; mem_addr_o = vec_base(kind_q); end
      ST_VHI: begin mem_rd_o = 1'b1; mem_addr_o = vec_base(kind_q) | 16'h0001; end
      default: ;
    endcase
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign mask_o   = mask_q;
  assign jammed_o = jam_q;
  assign done_o   = done_q;
  assign pc_o     = pc_q;
  assign status_o = st_q;
  assign sp_o     = sp_q;
endmodule

// File: rtl/cpu_intr_seq.sv
module cpu_intr_seq #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               boundary_i,
  input  logic [15:0]        pc_i,
  input  logic [7:0]         status_i,
  input  logic [7:0]         sp_i,
  input  logic               reset_req_i,
  input  logic               jam_set_i,
  input  logic [NUM_SRC-1:0] req_set_i,
  input  logic [NUM_SRC-1:0] req_clr_i,
  input  logic [7:0]         mem_rdata_i,
  output logic [15:0]        mem_addr_o,
  output logic               mem_wr_o,
  output logic               mem_rd_o,
  output logic [7:0]         mem_wdata_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [15:0]        pc_o,
  output logic [7:0]         status_o,
  output logic [7:0]         sp_o,
  output logic [NUM_SRC-1:0] pending_o,
  output logic               jammed_o
);
  logic idle, mask, check, take_nmi, take_irq;

  cis_req_reg #(.NUM_SRC(NUM_SRC)) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (req_set_i),
    .clr_i      (req_clr_i),
    .self_clr_i (check),
    .pend_o     (pending_o)
  );

  cis_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .boundary_i  (boundary_i),
    .idle_i      (idle),
    .reset_req_i (reset_req_i),
    .mask_i      (mask),
    .jammed_i    (jammed_o),
    .pend_i      (pending_o),
    .check_o     (check),
    .take_nmi_o  (take_nmi),
    .take_irq_o  (take_irq)
  );

  cis_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boundary_i  (boundary_i),
    .take_nmi_i  (take_nmi),
    .take_irq_i  (take_irq),
    .reset_req_i (reset_req_i),
    .jam_set_i   (jam_set_i),
    .pc_i        (pc_i),
    .status_i    (status_i),
    .sp_i        (sp_i),
    .mem_rdata_i (mem_rdata_i),
    .idle_o      (idle),
    .mask_o      (mask),
    .jammed_o    (jammed_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wr_o    (mem_wr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wdata_o (mem_wdata_o),
    .done_o      (done_o),
    .pc_o        (pc_o),
    .status_o    (status_o),
    .sp_o        (sp_o)
  );

  assign busy_o = ~idle | take_nmi | take_irq | reset_req_i;
endmodule

// File: rtl/cis_checker.sv
module cis_checker #(
  parameter int unsigned NUM_SRC = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               boundary_i,
  input logic               reset_req_i,
  input logic               idle,
  input logic [NUM_SRC-1:0] req_set_i,
  input logic [NUM_SRC-1:0] pending_o,
  input logic               jammed_o,
  input logic               busy_o,
  input logic               done_o,
  input logic               mem_wr_o,
  input logic               mem_rd_o,
  input logic [15:0]        mem_addr_o,
  input logic [7:0]         status_o
);
  logic [3:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run <= '0;
    else if (busy_o) busy_run <= (busy_run == 4'hF) ? busy_run : busy_run + 4'd1;
    else             busy_run <= '0;
  end

  // R4: stack writes go to page one
  a_r4_stack_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> mem_addr_o[15:8] == 8'h01);

  // R4: no sequence holds busy longer than 7 cycles
  a_r4_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_run < 4'd7);

  // R5: high vector byte read directly follows the low byte
  a_r5_vec_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && mem_addr_o[0]) |-> ($past(mem_rd_o) && $past(mem_addr_o) == mem_addr_o - 16'd1));

  // R6: maskable entry leaves interrupt disable set
  a_r6_irq_sets_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mem_addr_o) == 16'hFFFF) |-> status_o[2]);

  // R9: reset ends with status 0x04
  a_r9_reset_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mem_addr_o) == 16'hFFFD) |-> status_o == 8'h04);

  // R7: non-maskable bit self-clears at a check
  a_r7_nmi_selfclr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && idle && !reset_req_i && !req_set_i[0]) |=> !pending_o[0]);

  // R8: jammed core never starts an entry
  a_r8_jam_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jammed_o && boundary_i && idle && !reset_req_i) |-> !busy_o);
endmodule

bind cpu_intr_seq cis_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .boundary_i  (boundary_i),
  .reset_req_i (reset_req_i),
  .idle        (idle),
  .req_set_i   (req_set_i),
  .pending_o   (pending_o),
  .jammed_o    (jammed_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_wr_o    (mem_wr_o),
  .mem_rd_o    (mem_rd_o),
  .mem_addr_o  (mem_addr_o),
  .status_o    (status_o)
);

// File: tb/sim_cpu_intr_seq.sv
`timescale 1ns/1ps
module sim_cpu_intr_seq;
  localparam int N = 4;

  logic        clk = 0, rst_ni = 0;
  logic        boundary = 0, reset_req = 0, jam_set = 0;
  logic [15:0] pc_in = 0;
  logic [7:0]  st_in = 0, sp_in = 0;
  logic [N-1:0] rset = 0, rclr = 0;
  logic [7:0]  rdata;
  logic [15:0] maddr, pc_o;
  logic        mwr, mrd, busy, done, jam;
  logic [7:0]  wdata, st_o, sp_o;
  logic [N-1:0] pend;

  int checks = 0, fails = 0, cyc = 0;
  bit fin = 0;

  logic        a_busy[8], a_wr[8], a_rd[8], a_done[8];
  logic [15:0] a_addr[8];
  logic [7:0]  a_wd[8];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] vb(input logic [15:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction
  assign rdata = vb(maddr);

  cpu_intr_seq #(.NUM_SRC(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .boundary_i(boundary), .pc_i(pc_in),
    .status_i(st_in), .sp_i(sp_in), .reset_req_i(reset_req), .jam_set_i(jam_set),
    .req_set_i(rset), .req_clr_i(rclr), .mem_rdata_i(rdata),
    .mem_addr_o(maddr), .mem_wr_o(mwr), .mem_rd_o(mrd), .mem_wdata_o(wdata),
    .busy_o(busy), .done_o(done), .pc_o(pc_o), .status_o(st_o), .sp_o(sp_o),
    .pending_o(pend), .jammed_o(jam));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // index 0 is the already driven cycle; later cycles release strobes
  task automatic capture();
    for (int k = 0; k < 8; k++) begin
      if (k > 0) begin
        @(negedge clk);
        boundary = 0; reset_req = 0; rset = '0; rclr = '0; jam_set = 0;
        #1;
      end
      a_busy[k] = busy; a_wr[k] = mwr; a_rd[k] = mrd;
      a_addr[k] = maddr; a_wd[k] = wdata; a_done[k] = done;
    end
  endtask

  function automatic int nbusy();
    int n = 0;
    for (int k = 0; k < 8; k++) if (a_busy[k]) n++;
    return n;
  endfunction

  function automatic int nwr();
    int n = 0;
    for (int k = 0; k < 8; k++) if (a_wr[k]) n++;
    return n;
  endfunction

  task automatic entry(input logic [15:0] pc, input logic [7:0] st, input logic [7:0] sp,
                       input bit e_nmi, input bit e_irq, input logic [N-1:0] extra);
    logic [15:0] base;
    logic [7:0]  est;
    bit take;
    take = e_nmi | e_irq;
    @(negedge clk);
    boundary = 1; pc_in = pc; st_in = st; sp_in = sp; rset = extra;
    #1;
    chk(busy == take, "R2 busy at boundary", busy, take);
    capture();
    if (take) begin
      base = e_nmi ? 16'hFFFA : 16'hFFFE;
      est  = (st & ~8'h10) | (e_irq ? 8'h04 : 8'h00);
      chk(nbusy() == 7, "R4 busy cycles", nbusy(), 7);
      chk(a_wr[2] && a_addr[2] == {8'h01, sp} && a_wd[2] == pc[15:8], "R4 push pc hi",
          {a_addr[2], a_wd[2]}, {8'h01, sp, pc[15:8]});
      chk(a_wr[3] && a_addr[3] == {8'h01, sp - 8'd1} && a_wd[3] == pc[7:0], "R4 push pc lo",
          {a_addr[3], a_wd[3]}, {8'h01, sp - 8'd1, pc[7:0]});
      chk(a_wr[4] && a_addr[4] == {8'h01, sp - 8'd2} && a_wd[4] == ((st & ~8'h10) | 8'h20),
          "R4 push status", {a_addr[4], a_wd[4]}, {8'h01, sp - 8'd2, (st & ~8'h10) | 8'h20});
      chk(nwr() == 3, "R4 write count", nwr(), 3);
      chk(sp_o == sp - 8'd3, "R4 sp_o", sp_o, sp - 8'd3);
      chk(a_rd[5] && a_addr[5] == base && a_rd[6] && a_addr[6] == (base | 16'd1),
          "R5 vector reads", {a_addr[5], a_addr[6]}, {base, base | 16'd1});
      chk(a_done[7] && !a_busy[7], "R5 done pulse", {a_done[7], a_busy[7]}, 2'b10);
      chk(pc_o == {vb(base | 16'd1), vb(base)}, "R5 pc_o", pc_o, {vb(base | 16'd1), vb(base)});
      chk(st_o == est, "R6 status_o", st_o, est);
    end else begin
      chk(nbusy() == 0 && nwr() == 0 && !a_done[7], "R2 no entry", {nbusy(), nwr()}, 0);
    end
  endtask

  task automatic pulse_req(input logic [N-1:0] s, input logic [N-1:0] c);
    @(negedge clk); rset = s; rclr = c;
    @(negedge clk); rset = '0; rclr = '0;
  endtask

  initial begin
    logic [N-1:0] pexp;
    // reset state
    repeat (3) @(negedge clk);
    #1;
    chk(pend == '0, "R1 reset pending", pend, 0);
    chk(!jam && !mwr, "R9 reset jam/write", {jam, mwr}, 0);
    chk(busy, "R9 busy in reset", busy, 1);
    @(negedge clk); rst_ni = 1; #1;
    capture();
    chk(nbusy() == 6 && nwr() == 0, "R9 reset busy/writes", {nbusy(), nwr()}, {32'd6, 32'd0});
    chk(a_rd[4] && a_addr[4] == 16'hFFFC && a_rd[5] && a_addr[5] == 16'hFFFD, "R9 reset reads",
        {a_addr[4], a_addr[5]}, 32'hFFFCFFFD);
    chk(a_done[6] && pc_o == {vb(16'hFFFD), vb(16'hFFFC)} && st_o == 8'h04 && sp_o == 8'h00,
        "R9 reset result", {pc_o, st_o, sp_o}, {vb(16'hFFFD), vb(16'hFFFC), 16'h0400});

    // R2 R3 R6 R7 sweep: every pending mask against both mask samples
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 2; p++) begin
        logic [7:0] st, sp;
        logic [15:0] pc;
        bit en, ei;
        pulse_req('0, '1);
        entry(16'h1234, p[0] ? 8'h04 : 8'h00, 8'hFF, 0, 0, '0);   // sets mask sample
        pulse_req(m[N-1:0], '0);
        sp = 8'((m * 37 + p * 91) & 8'hFF);
        st = 8'((m * 53 + p * 29 + 8'h93) & 8'hFB) | (p[0] ? 8'h00 : 8'h04);
        pc = {8'(m * 17 + 3), 8'(p * 64 + m)};
        en = m[0];
        ei = !m[0] && (m[3:1] != 0) && !p[0];
        entry(pc, st, sp, en, ei, '0);
        pexp = m[N-1:0] & 4'b1100;
        chk(pend == pexp, "R7 pending after check", pend, pexp);
      end
    end

    // R1: set and clear in one cycle, clear wins
    pulse_req('0, '1);
    @(negedge clk); rset = 4'b1100; rclr = 4'b0100;
    @(negedge clk); rset = '0; rclr = '0; #1;
    chk(pend == 4'b1000, "R1 clear wins", pend, 4'b1000);

    // R7: NMI set in the check cycle survives
    pulse_req('0, '1);
    entry(16'h2000, 8'h00, 8'h80, 0, 0, '0);
    pulse_req(4'b0001, '0);
    entry(16'h2002, 8'h00, 8'h80, 1, 0, 4'b0001);
    chk(pend == 4'b0001, "R7 fresh set survives", pend, 4'b0001);

    // R3: after a maskable entry the sample is the new I flag
    pulse_req('0, '1);
    entry(16'h3000, 8'h00, 8'h40, 0, 0, '0);
    pulse_req(4'b0100, '0);
    entry(16'h3010, 8'h00, 8'h40, 0, 1, '0);
    entry(16'h3020, 8'h00, 8'h3D, 0, 0, '0);  // R3: masked by entry result
    entry(16'h3030, 8'h00, 8'h3D, 0, 1, '0);  // R3: sample now 0
    chk(pend == 4'b0100, "R7 level bit kept", pend, 4'b0100);

    // R8: jammed blocks entry, self-clear still applies
    pulse_req('0, '1);
    entry(16'h4000, 8'h00, 8'h10, 0, 0, '0);
    @(negedge clk); jam_set = 1;
    @(negedge clk); jam_set = 0; #1;
    chk(jam, "R8 jammed set", jam, 1);
    pulse_req(4'b0111, '0);
    entry(16'h4010, 8'h00, 8'h10, 0, 0, '0);
    chk(pend == 4'b0100, "R8 self-clear while jammed", pend, 4'b0100);

    // R9: reset request clears jam, keeps pending, no writes
    @(negedge clk); reset_req = 1; sp_in = 8'h77; #1;
    capture();
    chk(nbusy() == 7 && nwr() == 0, "R9 req busy/writes", {nbusy(), nwr()}, {32'd7, 32'd0});
    chk(a_addr[5] == 16'hFFFC && a_addr[6] == 16'hFFFD && a_done[7], "R9 req reads",
        {a_addr[5], a_addr[6]}, 32'hFFFCFFFD);
    chk(st_o == 8'h04 && sp_o == 8'h77 && !jam && pend == 4'b0100, "R9 req result",
        {st_o, sp_o, jam, pend}, {8'h04, 8'h77, 1'b0, 4'b0100});
    entry(16'h5000, 8'h00, 8'h20, 0, 0, '0);  // R3: sample is 1 after reset
    entry(16'h5010, 8'h00, 8'h20, 0, 1, '0);

    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !fin) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule